// File: doc/BRIEF.md
# Sequential BCD-to-Binary Converter

This block turns a word of packed decimal digits into an unsigned binary number, one bit per clock. A one-cycle start pulse captures the digits into a scratch register. The scratch register holds the digit field above a binary field that starts at zero. Each clock moves the whole register one place to the right, so the lowest digit bit falls into the top of the binary field. Any digit group that then reads 8 or more is reduced by 3. This undoes the add-3 correction that a binary-to-decimal shifter applies, so the block needs no multiply-by-ten hardware.

After N shifts the binary field holds the value, and done pulses for one cycle. The last shift has no correction step. busy stays high while the conversion runs. A start pulse seen during that time has no effect. If any captured digit was above 9, the invalid flag is raised with done, and the result then has no defined value. The parameter D sets the number of digits. The parameter N sets the output width, and N must be large enough to hold the value 10^D − 1.

Top module: `bcd_to_bin_seq`

## Requirements
- R1: While rst_n is low at a clock edge, busy, done, invalid and bin are all 0 after that edge, and a start pulse held during reset is not accepted.
- R2: A start pulse taken at an edge while busy is low captures bcd (4 bits per digit, digit k at bits 4k+3..4k, digit 0 least significant). After that edge busy is 1 and bin is 0.
- R3: Let edge k be the edge that accepts start. After edges k+1 to k+N−1, busy is 1 and done is 0. After edge k+N, done is 1 and busy is 0. After edge k+N+1, done is 0 again.
- R4: When every captured digit is 9 or less, bin equals the decimal value of the digits while done is 1. This holds for all-zero input, all-nines input and any mix in between.
- R5: For the digits 0-2-4-3, the result is 243 (binary 11110011 in the low bits). This needs the corrections 9→6, 8→5 and 10→7 along the way.
- R6: invalid is 1 only in the cycle in which done is 1, and only when at least one captured digit was greater than 9.
- R7: A start pulse while busy is 1 has no effect. The running conversion keeps its timing and its result, and the new bcd value is not captured.
- R8: Once a conversion ends, bin keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a conversion (taken only when idle) |
| bcd | input | 4*D | Packed decimal digits, least significant digit in the low nibble |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when bin is ready |
| bin | output | N | Binary result |
| invalid | output | 1 | Given with done when a captured digit was above 9 |

## Verification
The embedded properties check several rules on every cycle:
- the handshake: an accepted start raises busy, and done lasts one cycle and arrives only after busy;
- invalid never appears without done;
- bin holds steady while the block is idle and no start comes in;
- busy stays high through every iteration except the last.

The bench checks the rest through its scenarios:
- the numeric result against a decimal model, using random and directed digit sets;
- the exact N-cycle latency;
- the 243 case;
- flagging of digits above 9;
- that a start during busy does not disturb the running conversion.

// File: rtl/bcd_to_bin_seq.sv
module bcd_to_bin_seq #(
  parameter int D = 4,
  parameter int N = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [4*D-1:0] bcd,
  output logic           busy,
  output logic           done,
  output logic [N-1:0]   bin,
  output logic           invalid
);
  localparam int DW = 4 * D;
  localparam int CW = $clog2(N + 1);
  localparam longint MAXV = (10 ** D) - 1;

  logic [DW-1:0]   dig_q;
  logic [N-1:0]    bin_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q, done_q, inv_q, bad_q;
  logic [DW-1:0]   dig_fix;
  logic [D-1:0]    nib_bad;

  wire [DW+N-1:0] shifted = {1'b0, dig_q, bin_q[N-1:1]};
  wire            last    = (cnt_q == CW'(N - 1));
  wire            any_bad = |nib_bad;

  for (genvar g = 0; g < D; g++) begin : g_dig
    wire [3:0] nib = shifted[N+4*g +: 4];
    assign dig_fix[4*g +: 4] = (nib >= 4'd8 && !last) ? nib - 4'd3 : nib;
    assign nib_bad[g] = bcd[4*g +: 4] > 4'd9;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig_q  <= '0;
      bin_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      inv_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      inv_q  <= 1'b0;
      if (busy_q) begin
        dig_q <= dig_fix;
        bin_q <= shifted[N-1:0];
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          inv_q  <= bad_q;
        end
      end else if (start) begin
        dig_q  <= bcd;
        bin_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
        bad_q  <= any_bad;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign bin     = bin_q;
  assign invalid = inv_q;

  initial param_fit_chk: assert (MAXV < (longint'(1) << N));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && bin == '0));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != CW'(N - 1)) |=> (busy && !done));

  // R6
  invalid_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> done);

  // R8
  bin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(bin));
endmodule

// File: tb/test_bcd_to_bin_seq.sv
`timescale 1ns/1ps
module test_bcd_to_bin_seq;
  localparam int D = 4;
  localparam int N = 14;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [4*D-1:0] bcd = '0;
  logic           busy, done, invalid;
  logic [N-1:0]   bin;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bcd_to_bin_seq #(.D(D), .N(N)) i_bcd_to_bin_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .bcd(bcd),
    .busy(busy), .done(done), .bin(bin), .invalid(invalid));

  always #5 clk = ~clk;

  function automatic int dec_value(logic [4*D-1:0] v);
    int acc = 0;
    for (int k = D - 1; k >= 0; k--) acc = acc * 10 + int'(v[4*k +: 4]);
    return acc;
  endfunction

  function automatic bit has_bad(logic [4*D-1:0] v);
    for (int k = 0; k < D; k++) if (v[4*k +: 4] > 4'd9) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(logic [4*D-1:0] v, bit poke);
    int exp_v = dec_value(v);
    bit bad = has_bad(v);
    @(negedge clk);
    bcd = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(bin == '0, "R2 bin cleared", int'(bin), 0);
    for (int i = 1; i <= N; i++) begin
      if (poke && i == 3) begin
        start = 1'b1;
        bcd = 16'h9999;
      end
      @(negedge clk);
      start = 1'b0;
      if (i < N) begin
        chk(busy && !done, "R3 busy window", {busy, done}, 2);
      end else begin
        chk(done && !busy, "R3 done timing", {busy, done}, 1);
        chk(invalid == bad, "R6 invalid flag", invalid, bad);
        if (!bad) chk(int'(bin) == exp_v, poke ? "R7 result kept" : "R4 result", int'(bin), exp_v);
      end
    end
    @(negedge clk);
    chk(!done && !invalid, "R3 done one cycle", {done, invalid}, 0);
    chk(!busy, "R7 no second run", busy, 0);
    if (!bad) begin
      repeat (3) @(negedge clk);
      chk(int'(bin) == exp_v, "R8 bin held", int'(bin), exp_v);
    end
  endtask

  function automatic logic [4*D-1:0] rand_digits();
    logic [4*D-1:0] v;
    for (int k = 0; k < D; k++) v[4*k +: 4] = 4'($urandom % 10);
    return v;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    start = 1'b1;
    bcd = 16'h0123;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !invalid && bin == '0, "R1 reset state",
        {busy, done, invalid, |bin}, 0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 start in reset not kept", busy, 0);

    convert(16'h0243, 1'b0);
    chk(bin[7:0] == 8'b11110011, "R5 243 pattern", int'(bin[7:0]), 243);
    convert(16'h0000, 1'b0);
    convert(16'h9999, 1'b0);
    convert(16'h1000, 1'b0);
    convert(16'h0243, 1'b1);
    convert(16'h12A4, 1'b0);
    convert(16'hF000, 1'b0);
    for (int r = 0; r < 40; r++) convert(rand_digits(), (r % 7) == 3);
    for (int r = 0; r < 6; r++) begin
      logic [4*D-1:0] v = rand_digits();
      int p = int'($urandom % D);
      v[4*p +: 4] = 4'(10 + ($urandom % 6));
      convert(v, 1'b0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule